// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external host read and write a bank of 16-bit registers over a four-wire serial link. The block is always the slave: the host drives an active-low chip enable, a serial clock that idles low, and the data line toward the block. The block returns data on its own output line. All three host inputs are resynchronised into a faster system clock. All register traffic is issued in that system clock domain through a simple single-cycle strobe interface.

A transaction starts when chip enable falls and ends when it rises. The first byte is a command byte. Every later pair of bytes carries one 16-bit register value, with the high byte first. After each pair the register address moves on by one, so one transaction can sweep through consecutive registers. Read data is fetched as soon as the command byte or a completed pair arrives, which leaves the next byte ready for the host in time. The system clock must run at least four times faster than the serial clock.

Top module: `spi_reg_port`

## Requirements
- R1: `spi_miso_o` is high-impedance while `spi_csn_i` is high and is driven to 0 or 1 at every host sample point while `spi_csn_i` is low.
- R2: In the command byte, bit 7 selects a read (1) or a write (0) and bits 5:0 give the start address. Bit 6 has no effect on the address, the direction or the data.
- R3: Bytes in both directions move most significant bit first. Input bits are taken on the rising serial clock edge. The output bit changes only after a falling edge or after a byte completes.
- R4: On a write, `reg_wr_o` pulses for exactly one cycle after the third byte completes. The pulse carries `reg_wdata_o = {byte1, byte2}` and `reg_addr_o` equal to the command address.
- R5: If chip enable rises before a register's second data byte is complete, no write is issued for that register and its contents stay unchanged.
- R6: On a read, `reg_rd_o` pulses when the command byte completes and `reg_rdata_i` is sampled in that cycle. Bits 15:8 are shifted out during the second byte and bits 7:0 during the third.
- R7: Each further pair of data bytes accesses the previous address plus one, wrapping from 63 to 0. This holds for both reads and writes.
- R8: `spi_miso_o` sends all zeros during the command byte and during every byte of a write transaction.
- R9: `reg_rd_o` and `reg_wr_o` are never high in the same cycle, and neither is issued while the synchronised chip enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_csn_i | input | 1 | Active-low chip enable from the host |
| spi_sck_i | input | 1 | Serial clock from the host, idles low |
| spi_mosi_i | input | 1 | Serial data from the host |
| spi_miso_o | output | 1 | Serial data to the host, high-impedance when not selected |
| reg_rd_o | output | 1 | Single-cycle register read strobe |
| reg_wr_o | output | 1 | Single-cycle register write strobe |
| reg_addr_o | output | 6 | Register address, valid with either strobe |
| reg_wdata_o | output | 16 | Write data, valid with `reg_wr_o` |
| reg_rdata_i | input | 16 | Read data, sampled in the cycle of `reg_rd_o` |

## Verification
When a data pair completes, one system cycle does three things at once: it commits the register (a write, or the fetch of the next register on a read), it advances the address, and it reloads the output shifter. The bench provokes this with multi-register writes and reads that cross the 63-to-0 wrap. It judges the result from the bench's own register image and from every byte returned on the serial output. The other collision is a frame that ends just before or just after a pair completes. Partial transfers stopped at several bit counts must leave both the register image and the write count untouched.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  parameter int unsigned ADDR_W      = 6;
  parameter int unsigned DATA_W      = 16;
  parameter int unsigned SYNC_STAGES = 2;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CNT_W    = $clog2(BYTE_W);
  localparam int unsigned REG_BYTES = DATA_W / BYTE_W;
  localparam int unsigned IDX_W    = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1;
  localparam int unsigned RD_BIT   = BYTE_W - 1;

  typedef enum logic {
    ST_CMD  = 1'b0,
    ST_DATA = 1'b1
  } frame_st_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else            stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_s_i,
  input  logic              sck_s_i,
  input  logic              mosi_s_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_byte_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              sck_fall_o,
  output logic              miso_bit_o
);
  logic              sck_d_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-2:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic              sck_rise;

  assign sck_rise    = sck_s_i & ~sck_d_q & ~csn_s_i;
  assign sck_fall_o  = ~sck_s_i & sck_d_q & ~csn_s_i;
  assign byte_done_o = sck_rise && (bit_cnt_q == CNT_W'(BYTE_W - 1));
  assign rx_byte_o   = {rx_q, mosi_s_i};
  assign miso_bit_o  = tx_q[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d_q <= 1'b0;
    else         sck_d_q <= sck_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
    end else if (csn_s_i) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
    end else if (sck_rise) begin
      bit_cnt_q <= bit_cnt_q + 1'b1;
      rx_q      <= rx_byte_o[BYTE_W-2:0];
    end
  end

  // shift on falling edges inside a byte; the edge after bit 7 leaves the reloaded MSB
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                tx_q <= '0;
    else if (csn_s_i)                           tx_q <= '0;
    else if (load_i)                            tx_q <= load_byte_i;
    else if (sck_fall_o && (bit_cnt_q != '0))   tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
  end
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_s_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] load_byte_o
);
  frame_st_e                  state_q;
  logic                       is_rd_q;
  logic [ADDR_W-1:0]          addr_q;
  logic [IDX_W-1:0]           idx_q;
  logic [DATA_W-BYTE_W-1:0]   acc_q;
  logic [DATA_W-1:0]          rbuf_q;

  logic              cmd_done;
  logic              data_done;
  logic              last_byte;
  logic              commit;
  logic [ADDR_W-1:0] next_addr;

  assign cmd_done  = byte_done_i && (state_q == ST_CMD);
  assign data_done = byte_done_i && (state_q == ST_DATA);
  assign last_byte = (idx_q == IDX_W'(REG_BYTES - 1));
  assign commit    = data_done && last_byte;
  assign next_addr = addr_q + 1'b1;

  assign reg_wdata_o = {acc_q, rx_byte_i};
  assign reg_wr_o    = commit && !is_rd_q;
  assign reg_rd_o    = cmd_done ? rx_byte_i[RD_BIT] : (commit && is_rd_q);

  always_comb begin
    if (cmd_done)      reg_addr_o = rx_byte_i[ADDR_W-1:0];
    else if (reg_rd_o) reg_addr_o = next_addr;
    else               reg_addr_o = addr_q;
  end

  assign load_o = byte_done_i;
  always_comb begin
    if (reg_rd_o)                     load_byte_o = reg_rdata_i[DATA_W-1 -: BYTE_W];
    else if (data_done && is_rd_q)    load_byte_o = rbuf_q[DATA_W-1 -: BYTE_W];
    else                              load_byte_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      is_rd_q <= 1'b0;
      addr_q  <= '0;
      idx_q   <= '0;
      acc_q   <= '0;
      rbuf_q  <= '0;
    end else if (csn_s_i) begin
      state_q <= ST_CMD;
      is_rd_q <= 1'b0;
      idx_q   <= '0;
    end else if (cmd_done) begin
      state_q <= ST_DATA;
      is_rd_q <= rx_byte_i[RD_BIT];
      addr_q  <= rx_byte_i[ADDR_W-1:0];
      idx_q   <= '0;
      if (rx_byte_i[RD_BIT]) rbuf_q <= reg_rdata_i << BYTE_W;
    end else if (data_done) begin
      acc_q <= reg_wdata_o[DATA_W-BYTE_W-1:0];
      if (last_byte) begin
        idx_q  <= '0;
        addr_q <= next_addr;
        if (is_rd_q) rbuf_q <= reg_rdata_i << BYTE_W;
      end else begin
        idx_q  <= idx_q + 1'b1;
        rbuf_q <= rbuf_q << BYTE_W;
      end
    end
  end
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_csn_i,
  input  logic              spi_sck_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic              csn_s, sck_s, mosi_s;
  logic              byte_done, sck_fall, miso_bit, load;
  logic [BYTE_W-1:0] rx_byte, load_byte;

  spi_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({spi_csn_i, spi_sck_i, spi_mosi_i}),
    .q_o   ({csn_s, sck_s, mosi_s})
  );

  spi_bit_engine u_bits (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .csn_s_i    (csn_s),
    .sck_s_i    (sck_s),
    .mosi_s_i   (mosi_s),
    .load_i     (load),
    .load_byte_i(load_byte),
    .byte_done_o(byte_done),
    .rx_byte_o  (rx_byte),
    .sck_fall_o (sck_fall),
    .miso_bit_o (miso_bit)
  );

  spi_frame_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .csn_s_i    (csn_s),
    .byte_done_i(byte_done),
    .rx_byte_i  (rx_byte),
    .reg_rdata_i(reg_rdata_i),
    .reg_rd_o   (reg_rd_o),
    .reg_wr_o   (reg_wr_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .load_o     (load),
    .load_byte_o(load_byte)
  );

  assign spi_miso_o = spi_csn_i ? 1'bz : miso_bit;
endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic csn_s,
  input logic byte_done,
  input logic sck_fall,
  input logic miso_bit,
  input logic reg_rd_o,
  input logic reg_wr_o
);
  // R9
  one_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_rd_o, reg_wr_o}));

  // R9
  acc_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_o || reg_wr_o) |-> !csn_s);

  // R4
  wr_on_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> byte_done);

  // R4
  wr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  // R3
  miso_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(miso_bit) && $past(!csn_s)) |-> ($past(sck_fall) || $past(byte_done)));
endmodule

bind spi_reg_port spi_reg_port_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .csn_s    (csn_s),
  .byte_done(byte_done),
  .sck_fall (sck_fall),
  .miso_bit (miso_bit),
  .reg_rd_o (reg_rd_o),
  .reg_wr_o (reg_wr_o)
);

// File: tb/sim_spi_reg_port.sv
module sim_spi_reg_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csn = 1'b1;
  logic        sck = 1'b0;
  logic        mosi = 1'b0;
  wire         miso;
  logic        rd, wr;
  logic [5:0]  addr;
  logic [15:0] wdata, rdata;

  logic [15:0] rf [64];
  int          wr_cnt = 0;
  int          bad_acc = 0;
  int          csn_hi_cyc = 0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  logic [7:0]  tx_b [16];
  logic [7:0]  rx_b [16];
  bit          got_z;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .spi_csn_i(csn), .spi_sck_i(sck),
    .spi_mosi_i(mosi), .spi_miso_o(miso), .reg_rd_o(rd), .reg_wr_o(wr),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  assign rdata = rf[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) rf[i] <= 16'h1000 + 16'(i);
    end else if (wr) begin
      rf[addr] <= wdata;
    end
  end

  always @(negedge clk) begin
    if (wr) wr_cnt++;
    csn_hi_cyc = csn ? csn_hi_cyc + 1 : 0;
    if (rst_n && ((rd && wr) || ((rd || wr) && csn_hi_cyc > 4))) bad_acc++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input int nbits);
    got_z = 0;
    for (int b = 0; b < 16; b++) rx_b[b] = 8'h00;
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx_b[i/8][7-(i%8)];
      repeat (HALF) @(negedge clk);
      if (miso !== 1'b0 && miso !== 1'b1) got_z = 1;
      rx_b[i/8][7-(i%8)] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    mosi = 1'b0;
    repeat (4*HALF) @(negedge clk);
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h0b3d) ^ 16'h5a17);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(miso === 1'bz, "R1 reset miso", {31'd0, miso}, 32'h0);
    chk(!rd && !wr, "R9 reset strobes", {30'd0, rd, wr}, 32'h0);

    // R4 R2 R8 write sweep, bit 6 toggled
    for (int a = 0; a < 64; a++) begin
      base = wr_cnt;
      tx_b[0] = {1'b0, a[0], 6'(a)};
      tx_b[1] = pat(a)[15:8];
      tx_b[2] = pat(a)[7:0];
      xfer(24);
      chk(wr_cnt == base + 1, "R4 write count", wr_cnt, base + 1);
      chk(rf[a] == pat(a), "R4 R2 write value", rf[a], pat(a));
      chk({rx_b[0], rx_b[1], rx_b[2]} == 24'h0, "R8 miso on write",
          {rx_b[0], rx_b[1], rx_b[2]}, 0);
      chk(!got_z, "R1 miso driven", got_z, 0);
    end

    // R6 R3 read sweep, bit 6 set on odd addresses
    for (int a = 0; a < 64; a++) begin
      tx_b[0] = {1'b1, a[0], 6'(a)};
      tx_b[1] = 8'h5c;
      tx_b[2] = 8'ha3;
      xfer(24);
      chk({rx_b[1], rx_b[2]} == pat(a), "R6 R3 read data", {rx_b[1], rx_b[2]}, pat(a));
      chk(rx_b[0] == 8'h00, "R8 miso on command", rx_b[0], 0);
      chk(!got_z, "R1 miso driven", got_z, 0);
      chk(miso === 1'bz, "R1 miso released", {31'd0, miso}, 0);
      chk(rf[a] == pat(a), "R6 read leaves register", rf[a], pat(a));
    end

    // R3 bit order with sparse pattern
    tx_b[0] = 8'h07; tx_b[1] = 8'h80; tx_b[2] = 8'h01;
    xfer(24);
    tx_b[0] = 8'h87;
    xfer(24);
    chk({rx_b[1], rx_b[2]} == 16'h8001, "R3 msb first", {rx_b[1], rx_b[2]}, 16'h8001);

    // R5 early termination at several bit counts
    foreach (tx_b[k]) tx_b[k] = 8'hff;
    tx_b[0] = 8'h05;
    for (int n = 0; n < 5; n++) begin
      int bits;
      bits = (n == 0) ? 8 : (n == 1) ? 16 : (n == 2) ? 20 : (n == 3) ? 23 : 3;
      base = wr_cnt;
      xfer(bits);
      chk(wr_cnt == base, "R5 no write on short frame", wr_cnt, base);
      chk(rf[5] == pat(5), "R5 register kept", rf[5], pat(5));
    end

    // R7 streamed write across wrap: 61,62,63,0,1
    base = wr_cnt;
    tx_b[0] = 8'h3d;
    for (int r = 0; r < 5; r++) begin
      tx_b[1 + 2*r] = 8'(8'hc0 + r);
      tx_b[2 + 2*r] = 8'(8'h11 * r);
    end
    xfer(88);
    chk(wr_cnt == base + 5, "R7 stream write count", wr_cnt, base + 5);
    for (int r = 0; r < 5; r++) begin
      int a;
      a = (61 + r) % 64;
      chk(rf[a] == {8'(8'hc0 + r), 8'(8'h11 * r)}, "R7 stream write value", rf[a],
          {8'(8'hc0 + r), 8'(8'h11 * r)});
    end

    // R7 streamed read across wrap: 62,63,0,1,2
    tx_b[0] = 8'hbe;
    xfer(88);
    for (int r = 0; r < 5; r++) begin
      int a;
      a = (62 + r) % 64;
      chk({rx_b[1 + 2*r], rx_b[2 + 2*r]} == rf[a], "R7 stream read value",
          {rx_b[1 + 2*r], rx_b[2 + 2*r]}, rf[a]);
    end
    chk(!got_z, "R1 miso driven in stream", got_z, 0);

    // R9 strobe exclusivity and framing
    chk(bad_acc == 0, "R9 strobe conflicts", bad_acc, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule